// File: doc/BRIEF.md
# Floating-Point Status Register with Split Condition Fields

This block keeps the floating-point status word of a processor core as separate parts instead of one flat register. The condition-code results of floating-point compares are held in up to four independent 2-bit fields, each exposed on its own so that a compare unit can write one of them and a branch unit can read any of them without touching the rest of the word. The control part holds the rounding mode, the trap-enable mask, the accrued-exception flags, the current-exception flags and the trap-type code. A fixed version number is supplied as a parameter.

Two load commands refresh the word from a data bus. The narrow load carries a 32-bit word and refreshes only the first condition field. The wide load carries a 64-bit word and refreshes all of them. A read output reassembles the 64-bit architectural word every cycle, with each condition field placed at its fixed bit position. A parameter selects either the full four-field build or a reduced build with a single condition field.

Top module: `fpstat_reg`

## Requirements
- R1: Reset clears every condition field and every control field. While reset is held and just after it, the read word equals the version parameter placed at bits 19:17, and all other bits are zero.
- R2: A 32-bit load replaces rounding mode (data bits 31:30), trap-enable mask (27:23), accrued flags (9:5), current flags (4:0) and condition field 0 (11:10) from the loaded word one cycle later. Condition fields 1 to 3 keep their values.
- R3: A 64-bit load replaces the same control fields and condition field 0 from its low 32 bits. It also sets condition field 1 from data bits 33:32, field 2 from 35:34 and field 3 from 37:36.
- R4: No load changes the trap-type field at read bits 16:14, so after reset it reads 0. Load data bits 12, 13, 14 to 22, 28, 29 and 38 to 63 have no effect.
- R5: The read word places current flags at 4:0, accrued flags at 9:5, field 0 at 11:10, trap type at 16:14, version at 19:17, trap-enable mask at 27:23, rounding mode at 31:30, field 1 at 33:32, field 2 at 35:34 and field 3 at 37:36. All other bits read zero.
- R6: A compare write with select s (0 to 3) sets condition field s to the given 2-bit code one cycle later. The other fields hold. With no load and no compare, every field holds.
- R7: When a compare write and a load fall in the same cycle, the compare value wins for the selected field only. Every other field takes the load value.
- R8: When both loads are requested in the same cycle, the 64-bit load is performed and the 32-bit load is dropped.
- R9: The rounding-mode output equals read bits 31:30.
- R10: The condition output carries field i at bits 2i+1:2i.
- R11: In the single-field build, read bits 37:32 are always zero, a compare with a select of 1 to 3 has no effect, and the condition output is 2 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld32_en | input | 1 | 32-bit load command |
| ld32_data | input | 32 | 32-bit load data |
| ld64_en | input | 1 | 64-bit load command |
| ld64_data | input | 64 | 64-bit load data |
| cmp_we | input | 1 | Compare result write |
| cmp_sel | input | 2 | Condition field selected by the compare |
| cmp_cc | input | 2 | Compare code (0 equal, 1 less, 2 greater, 3 unordered) |
| rd_word | output | 64 | Assembled status word |
| cc_out | output | 2*CC_FIELDS | All condition fields, field i at bits 2i+1:2i |
| rmode | output | 2 | Current rounding mode |

## Verification
A compare result write and a load can fall in the same cycle, and so can the two loads. The stimulus table contains vectors that assert a compare together with a wide load, a compare together with a narrow load, and both loads at once. Each cycle the bench model applies the load first and then overrides only the selected field with the compare code. It then compares the whole read word and the condition output of both builds against that model, so a compare that spills into a neighbouring field is caught, and so is a load that overrides the compare.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
   localparam int CEXC_LSB = 0;
   localparam int AEXC_LSB = 5;
   localparam int CC0_LSB  = 10;
   localparam int TT_LSB   = 14;
   localparam int VER_LSB  = 17;
   localparam int TEM_LSB  = 23;
   localparam int RND_LSB  = 30;
   localparam int CCX_LSB  = 32;
   localparam int EXC_W    = 5;
   localparam int TT_W     = 3;
   localparam int VER_W    = 3;
   localparam int RND_W    = 2;
   localparam int CC_W     = 2;
   localparam int MAX_CC   = 4;
   localparam int WORD_W   = 64;
   localparam int NARROW_W = 32;

   typedef struct packed {
      logic [RND_W-1:0] rnd;
      logic [EXC_W-1:0] tem;
      logic [EXC_W-1:0] aexc;
      logic [EXC_W-1:0] cexc;
      logic [TT_W-1:0]  ttype;
   } ctl_t;

   function automatic int cc_lsb(input int idx);
      return (idx == 0) ? CC0_LSB : CCX_LSB + CC_W * (idx - 1);
   endfunction
endpackage

// File: rtl/fpstat_ctl.sv
module fpstat_ctl
   import fpstat_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_en,
   input  logic [NARROW_W-1:0] ld_word,
   output ctl_t                ctl_q
);
   logic unused_ld_bits;
   assign unused_ld_bits = ^{ld_word[22:10], ld_word[29:28]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ld_en) begin
         ctl_q.rnd  <= ld_word[RND_LSB  +: RND_W];
         ctl_q.tem  <= ld_word[TEM_LSB  +: EXC_W];
         ctl_q.aexc <= ld_word[AEXC_LSB +: EXC_W];
         ctl_q.cexc <= ld_word[CEXC_LSB +: EXC_W];
      end
   end

   a_r4_ttype_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> $stable(ctl_q.ttype));
   a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (ctl_q.rnd == $past(ld_word[31:30])) && (ctl_q.cexc == $past(ld_word[4:0]))
                && (ctl_q.tem == $past(ld_word[27:23])) && (ctl_q.aexc == $past(ld_word[9:5])));
   a_r6_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(ctl_q));
endmodule

// File: rtl/fpstat_ccf.sv
module fpstat_ccf
   import fpstat_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_en,
   input  logic [CC_W-1:0] ld_val,
   input  logic            cmp_en,
   input  logic [CC_W-1:0] cmp_val,
   output logic [CC_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (cmp_en) q <= cmp_val;
      else if (ld_en)  q <= ld_val;
   end

   a_r7_cmp_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en |=> q == $past(cmp_val));
   a_r2_cc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !cmp_en) |=> q == $past(ld_val));
   a_r6_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !cmp_en) |=> $stable(q));
endmodule

// File: rtl/fpstat_rdasm.sv
module fpstat_rdasm
   import fpstat_pkg::*;
#(
   parameter int               NCC     = 4,
   parameter logic [VER_W-1:0] VERSION = 3'd0
) (
   input  ctl_t                ctl_q,
   input  logic [CC_W*NCC-1:0] cc_flat,
   output logic [WORD_W-1:0]   word
);
   always_comb begin
      word = '0;
      word[CEXC_LSB +: EXC_W] = ctl_q.cexc;
      word[AEXC_LSB +: EXC_W] = ctl_q.aexc;
      word[TT_LSB   +: TT_W]  = ctl_q.ttype;
      word[VER_LSB  +: VER_W] = VERSION;
      word[TEM_LSB  +: EXC_W] = ctl_q.tem;
      word[RND_LSB  +: RND_W] = ctl_q.rnd;
      for (int i = 0; i < NCC; i++) begin
         word[cc_lsb(i) +: CC_W] = cc_flat[CC_W*i +: CC_W];
      end
   end
endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
   import fpstat_pkg::*;
#(
   parameter int               CC_FIELDS  = 4,
   parameter logic [2:0]       VERSION_ID = 3'd5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld32_en,
   input  logic [31:0]               ld32_data,
   input  logic                      ld64_en,
   input  logic [63:0]               ld64_data,
   input  logic                      cmp_we,
   input  logic [1:0]                cmp_sel,
   input  logic [1:0]                cmp_cc,
   output logic [63:0]               rd_word,
   output logic [2*CC_FIELDS-1:0]    cc_out,
   output logic [1:0]                rmode
);
   localparam int CCF_W = CC_W * CC_FIELDS;

   initial begin
      a_cfg_fields: assert (CC_FIELDS == 1 || CC_FIELDS == MAX_CC)
         else $error("CC_FIELDS must be 1 or %0d", MAX_CC);
   end

   logic                ld_any;
   logic [NARROW_W-1:0] low_word;
   ctl_t                ctl_q;
   logic [CCF_W-1:0]    cc_flat;
   logic                unused_hi_bits;

   assign ld_any         = ld32_en | ld64_en;
   assign low_word       = ld64_en ? ld64_data[NARROW_W-1:0] : ld32_data;
   assign unused_hi_bits = ^ld64_data[WORD_W-1:NARROW_W];

   fpstat_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_any),
      .ld_word (low_word),
      .ctl_q   (ctl_q)
   );

   for (genvar i = 0; i < CC_FIELDS; i++) begin : g_cc
      logic            f_ld;
      logic [CC_W-1:0] f_val;
      if (i == 0) begin : g_first
         assign f_ld  = ld_any;
         assign f_val = low_word[CC0_LSB +: CC_W];
      end else begin : g_ext
         assign f_ld  = ld64_en;
         assign f_val = ld64_data[cc_lsb(i) +: CC_W];
      end
      fpstat_ccf u_ccf (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_en   (f_ld),
         .ld_val  (f_val),
         .cmp_en  (cmp_we && (cmp_sel == 2'(i))),
         .cmp_val (cmp_cc),
         .q       (cc_flat[CC_W*i +: CC_W])
      );
   end

   fpstat_rdasm #(.NCC(CC_FIELDS), .VERSION(VERSION_ID)) u_rdasm (
      .ctl_q   (ctl_q),
      .cc_flat (cc_flat),
      .word    (rd_word)
   );

   assign cc_out = cc_flat;
   assign rmode  = ctl_q.rnd;

   a_r8_wide_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ld32_en && ld64_en) |=> rmode == $past(ld64_data[31:30]));
   a_r10_cc0_view: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_we && cmp_sel == 2'd0) |=> cc_out[1:0] == $past(cmp_cc));
endmodule

// File: tb/fpstat_reg_tb.sv
module fpstat_reg_tb_top;
   localparam int         CLK_PERIOD = 10;
   localparam logic [2:0] VER        = 3'd5;
   localparam int         NV         = 12;

   typedef struct packed {
      logic [23:0] tag;
      logic        l32;
      logic        l64;
      logic        cm;
      logic [1:0]  sel;
      logic [1:0]  cc;
      logic [31:0] d32;
      logic [63:0] d64;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{"R2", 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 32'hFFFF_FFFF, 64'h0},
      '{"R3", 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0, 64'h0000_0025_4000_0A15},
      '{"R6", 1'b0, 1'b0, 1'b1, 2'd2, 2'd3, 32'h0, 64'h0},
      '{"R6", 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 32'h0, 64'h0},
      '{"R2", 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 32'h8280_0400, 64'h0},
      '{"R7", 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF},
      '{"R8", 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 32'hFFFF_FFFF, 64'h0000_0010_0000_0000},
      '{"R6", 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 32'h1234_5678, 64'h0},
      '{"R7", 1'b1, 1'b0, 1'b1, 2'd3, 2'd1, 32'h4000_0800, 64'h0},
      '{"R6", 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 32'h0, 64'h0},
      '{"R3", 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0, 64'h0000_0038_C0A0_0C1F},
      '{"R2", 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0, 64'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ld32_en, ld64_en, cmp_we;
   logic [31:0] ld32_data;
   logic [63:0] ld64_data;
   logic [1:0]  cmp_sel, cmp_cc;
   logic [63:0] rd_word, rd_word_n;
   logic [7:0]  cc_out;
   logic [1:0]  cc_out_n;
   logic [1:0]  rmode, rmode_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [4:0] m_cexc, m_aexc, m_tem;
   logic [1:0] m_rnd;
   logic [1:0] m_cc [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   fpstat_reg #(.CC_FIELDS(4), .VERSION_ID(VER)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld32_en(ld32_en), .ld32_data(ld32_data),
      .ld64_en(ld64_en), .ld64_data(ld64_data), .cmp_we(cmp_we), .cmp_sel(cmp_sel),
      .cmp_cc(cmp_cc), .rd_word(rd_word), .cc_out(cc_out), .rmode(rmode));

   fpstat_reg #(.CC_FIELDS(1), .VERSION_ID(VER)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .ld32_en(ld32_en), .ld32_data(ld32_data),
      .ld64_en(ld64_en), .ld64_data(ld64_data), .cmp_we(cmp_we), .cmp_sel(cmp_sel),
      .cmp_cc(cmp_cc), .rd_word(rd_word_n), .cc_out(cc_out_n), .rmode(rmode_n));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cexc = '0; m_aexc = '0; m_tem = '0; m_rnd = '0;
      for (int i = 0; i < 4; i++) m_cc[i] = '0;
   endtask

   function automatic logic [63:0] exp_word();
      logic [63:0] w = '0;
      w[4:0]   = m_cexc;
      w[9:5]   = m_aexc;
      w[11:10] = m_cc[0];
      w[19:17] = VER;
      w[27:23] = m_tem;
      w[31:30] = m_rnd;
      w[33:32] = m_cc[1];
      w[35:34] = m_cc[2];
      w[37:36] = m_cc[3];
      return w;
   endfunction

   task automatic check_all(input string tag);
      logic [63:0] e = exp_word();
      check({tag, " read"}, rd_word, e);
      check("R10 cc_out", {56'd0, cc_out}, {56'd0, m_cc[3], m_cc[2], m_cc[1], m_cc[0]});
      check("R9 rmode", {62'd0, rmode}, {62'd0, m_rnd});
      check("R11 narrow read", rd_word_n, e & ~(64'h3F << 32));
      check("R11 narrow cc_out", {62'd0, cc_out_n}, {62'd0, m_cc[0]});
   endtask

   // Drive one cycle just after a falling edge, update the model, check at the next falling edge.
   task automatic step(input vec_t v);
      logic [31:0] low;
      ld32_en = v.l32; ld64_en = v.l64; cmp_we = v.cm;
      cmp_sel = v.sel; cmp_cc = v.cc; ld32_data = v.d32; ld64_data = v.d64;
      if (v.l32 || v.l64) begin
         low    = v.l64 ? v.d64[31:0] : v.d32;
         m_cexc = low[4:0];  m_aexc = low[9:5];  m_tem = low[27:23];
         m_rnd  = low[31:30]; m_cc[0] = low[11:10];
         if (v.l64) begin
            m_cc[1] = v.d64[33:32]; m_cc[2] = v.d64[35:34]; m_cc[3] = v.d64[37:36];
         end
      end
      if (v.cm) m_cc[v.sel] = v.cc;
      @(negedge clk);
      check_all(string'(v.tag));
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      vec_t v;
      rst_n = 1'b0; ld32_en = 0; ld64_en = 0; cmp_we = 0;
      ld32_data = '0; ld64_data = '0; cmp_sel = '0; cmp_cc = '0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset read", rd_word, {44'd0, VER, 17'd0});
      check("R1 reset cc", {56'd0, cc_out}, 64'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) step(VECS[k]);

      // R4: trap type and reserved bits ignored on an all-ones wide load
      v = '{"R4", 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF};
      step(v);
      check("R4 ttype", {61'd0, rd_word[16:14]}, 64'd0);
      check("R4 reserved", {rd_word[63:38], rd_word[29:28], rd_word[22:20], rd_word[13:12]}, 64'd0);
      check("R5 version", {61'd0, rd_word[19:17]}, {61'd0, VER});

      // R11: compare to a missing field leaves the narrow build untouched
      v = '{"R11", 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 32'h0, 64'h0};
      step(v);
      check("R11 narrow hold", {62'd0, cc_out_n}, 64'd3);

      // R7: compare on field 0 beats a narrow load of the same field
      v = '{"R7", 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0C00, 64'h0};
      step(v);
      check("R7 field0", {62'd0, cc_out[1:0]}, 64'd2);

      // R8: both loads, wide data wins for field 0 too
      v = '{"R8", 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0000_0C00, 64'h0000_0000_0000_0400};
      step(v);
      check("R8 field0", {62'd0, cc_out[1:0]}, 64'd1);

      // R1: reset mid-run clears everything
      ld32_en = 0; ld64_en = 0; cmp_we = 0;
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      check_all("R1 midrun");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule